// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Seconds Snapshot

This block keeps wall-clock time as two counters: a milliseconds count that runs from 0 to 999 and a 32-bit seconds count. A prescaler divides the system clock down to a one-millisecond enable, so the pair advances at 1 kHz. The block runs without a gap for as long as its clock runs. Nothing on the bus pauses it.

Software reaches the counters through a small synchronous 32-bit register port. The milliseconds register returns the sub-second count. Reading it has one side effect: the current seconds value is copied into a separate snapshot register on the same clock edge. Software reads milliseconds first and the snapshot second. The two values then describe one instant, even if a seconds rollover happens between the two accesses. That instant is `seconds * 1000 + milliseconds`, treated as a 32-bit wrapping value. Writing the live seconds register sets a new time and starts a fresh millisecond.

Top module: `rtc_ms_shadow`

## Requirements
- R1: After a synchronous active-low reset, the live seconds value, the milliseconds value and the snapshot are all 0, and `bus_rdata` is 0.
- R2: With no write to the seconds register, the milliseconds value rises by exactly 1 every `CLK_PER_MS` clock cycles. The first increment after a reset or a seconds write comes `CLK_PER_MS` cycles after that event.
- R3: When a millisecond tick finds the milliseconds value at 999, the milliseconds value becomes 0 and the live seconds value rises by 1 on the same edge. The milliseconds value never exceeds 999.
- R4: The live seconds value wraps from 0xFFFFFFFF to 0 on a rollover.
- R5: A read of byte offset 0x10 returns the milliseconds value in bits [9:0] of `bus_rdata`, with all higher bits 0. On that same edge it copies the live seconds value into the snapshot. This applies even when the same edge is a rollover: the copy gets the seconds value from before the edge.
- R6: A read of byte offset 0x0C returns the snapshot. After a read of 0x10 followed by a read of 0x0C, `snapshot * 1000 + ms` (mod 2^32) equals the time at the moment of the 0x10 read.
- R7: A write to byte offset 0x08 loads the live seconds value from `bus_wdata`, clears the milliseconds value and restarts the prescaler.
- R8: The snapshot changes only on a read of 0x10. Writes to 0x0C, 0x10 or any unmapped offset change no state.
- R9: Read data appears on `bus_rdata` in the cycle after the access. A read of 0x08 returns the live seconds value, a read of an unmapped offset returns 0, and `bus_rdata` is 0 after any cycle without a read.
- R10: If a seconds write and a millisecond tick fall on the same edge, the write wins: the seconds value takes the written value and the milliseconds value is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read (valid with `bus_sel`) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |

## Verification
Embedded properties check every cycle that the milliseconds value stays within 0 to 999. They check that it moves only on a tick or a seconds load, and that a tick at 999 produces the rollover and seconds increment together. They also cover the effect of a seconds load, that a milliseconds read copies the pre-edge seconds value, and that the snapshot holds in all other cycles. Other behaviour needs the bench's scenarios. This includes the tick spacing measured at the ports, the snapshot pair staying consistent across a real rollover, the seconds wrap at 2^32, the priority of a write over a tick landing on the same edge, and writes to read-only or unmapped offsets leaving every readable value unchanged.

// File: rtl/rtc_pkg.sv
// Package: rtc_pkg
// Shared register offsets and the register-select type of the millisecond
// real-time counter. Assumes byte addressing with word-aligned registers.
package rtc_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_SEC_LIVE = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SEC_SNAP = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MSEC     = 8'h10;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SEC_LIVE,
        SEL_SEC_SNAP,
        SEL_MSEC
    } rtc_sel_e;

    // Map a byte offset to the register it names; unmapped gives SEL_NONE.
    function automatic rtc_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        rtc_sel_e s;
        case (ofs)
            OFS_SEC_LIVE: s = SEL_SEC_LIVE;
            OFS_SEC_SNAP: s = SEL_SEC_SNAP;
            OFS_MSEC:     s = SEL_MSEC;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
// Module: rtc_tick_gen
// Divides the system clock into a one-cycle millisecond enable.
// Assumes CLK_PER_MS >= 2. A restart pulse returns the phase to zero, so the
// next tick follows a full CLK_PER_MS cycles later.
module rtc_tick_gen #(
    parameter int CLK_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = $clog2(CLK_PER_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

    logic [PRE_W-1:0] phase_q;

    // Advance the prescaler phase, wrapping at the end of each millisecond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || phase_q == PRE_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == PRE_LAST);

    // Ticks are isolated pulses, and none lands straight after a restart.
    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    p_restart_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

endmodule

// File: rtl/rtc_time_core.sv
// Module: rtc_time_core
// Holds the live milliseconds (0..MS_PER_SEC-1) and seconds counts.
// A load sets the seconds count and clears milliseconds, and takes priority
// over a tick on the same edge. Seconds wrap modulo 2^SEC_W.
module rtc_time_core #(
    parameter int MS_PER_SEC = 1000,
    parameter int SEC_W      = 32,
    parameter int MS_W       = $clog2(MS_PER_SEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    output logic [SEC_W-1:0] sec,
    output logic [MS_W-1:0]  msec
);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

    logic [SEC_W-1:0] sec_q;
    logic [MS_W-1:0]  msec_q;

    // Update the time: load first, then millisecond step with carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            msec_q <= '0;
        end else if (load) begin
            sec_q  <= load_val;
            msec_q <= '0;
        end else if (tick) begin
            if (msec_q == MS_LAST) begin
                msec_q <= '0;
                sec_q  <= sec_q + 1'b1;
            end else begin
                msec_q <= msec_q + 1'b1;
            end
        end
    end

    assign sec  = sec_q;
    assign msec = msec_q;

    p_ms_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        msec_q <= MS_LAST);
    p_ms_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(msec_q) && $stable(sec_q)));
    p_rollover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && msec_q == MS_LAST) |=>
            (msec_q == '0 && sec_q == $past(sec_q) + 1'b1));
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sec_q == $past(load_val) && msec_q == '0));

endmodule

// File: rtl/rtc_regfile.sv
// Module: rtc_regfile
// Register decode of the counter: live seconds (read/write), seconds snapshot
// (read-only) and milliseconds (read-only; a read captures the snapshot).
// Read data is registered and is zero after any cycle without a read.
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int MS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [SEC_W-1:0]  sec,
    input  logic [MS_W-1:0]   msec,
    output logic              load,
    output logic [SEC_W-1:0]  load_val,
    output logic [DATA_W-1:0] bus_rdata
);
    rtc_sel_e          sel;
    logic              rd_any;
    logic              rd_msec;
    logic [SEC_W-1:0]  snap_q;
    logic [DATA_W-1:0] rdata_q;

    // Decode the access into a register select and the side-effect strobes.
    always_comb begin
        sel      = decode_ofs(bus_addr);
        rd_any   = bus_sel && !bus_wr;
        rd_msec  = rd_any && (sel == SEL_MSEC);
        load     = bus_sel && bus_wr && (sel == SEL_SEC_LIVE);
        load_val = bus_wdata[SEC_W-1:0];
    end

    // Capture live seconds into the snapshot when milliseconds are read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rd_msec) begin
            snap_q <= sec;
        end
    end

    // Register the read data; zero when no read is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_any) begin
            case (sel)
                SEL_SEC_LIVE: rdata_q <= DATA_W'(sec);
                SEL_SEC_SNAP: rdata_q <= DATA_W'(snap_q);
                SEL_MSEC:     rdata_q <= DATA_W'(msec);
                default:      rdata_q <= '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;

    p_snap_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_msec |=> snap_q == $past(sec));
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_msec |=> $stable(snap_q));
    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> bus_rdata == '0);

endmodule

// File: rtl/rtc_ms_shadow.sv
// Module: rtc_ms_shadow (top)
// Millisecond real-time counter with a seconds snapshot taken on each
// milliseconds read. Assumes CLK_PER_MS >= 2 and SEC_W <= 32.
module rtc_ms_shadow
    import rtc_pkg::*;
#(
    parameter int CLK_PER_MS = 50000,
    parameter int MS_PER_SEC = 1000,
    parameter int SEC_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int MS_W = $clog2(MS_PER_SEC);

    logic             tick;
    logic             load;
    logic [SEC_W-1:0] load_val;
    logic [SEC_W-1:0] sec;
    logic [MS_W-1:0]  msec;

    rtc_tick_gen #(
        .CLK_PER_MS (CLK_PER_MS)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (tick)
    );

    rtc_time_core #(
        .MS_PER_SEC (MS_PER_SEC),
        .SEC_W      (SEC_W),
        .MS_W       (MS_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .sec      (sec),
        .msec     (msec)
    );

    rtc_regfile #(
        .SEC_W (SEC_W),
        .MS_W  (MS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sec       (sec),
        .msec      (msec),
        .load      (load),
        .load_val  (load_val),
        .bus_rdata (bus_rdata)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> bus_rdata == '0);

endmodule

// File: tb/rtc_ms_shadow_bench.sv
module rtc_ms_shadow_bench;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rtc_ms_shadow #(.CLK_PER_MS(P)) u_rtc_ms_shadow (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Reference model built from the requirements.
    int          m_pre;
    int          m_ms;
    logic [31:0] m_sec, m_snap, m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre <= 0; m_ms <= 0; m_sec <= '0; m_snap <= '0; m_rd <= '0;
        end else begin
            m_rd <= '0;
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    8'h08: m_rd <= m_sec;
                    8'h0C: m_rd <= m_snap;
                    8'h10: m_rd <= 32'(m_ms);
                    default: m_rd <= '0;
                endcase
                if (bus_addr == 8'h10) m_snap <= m_sec;
            end
            if (bus_sel && bus_wr && bus_addr == 8'h08) begin
                m_sec <= bus_wdata; m_ms <= 0; m_pre <= 0;
            end else if (m_pre == P - 1) begin
                m_pre <= 0;
                if (m_ms == 999) begin m_ms <= 0; m_sec <= m_sec + 1; end
                else m_ms <= m_ms + 1;
            end else begin
                m_pre <= m_pre + 1;
            end
        end
    end

    function automatic logic [31:0] combined(input logic [31:0] s, input logic [31:0] ms);
        return s * 32'd1000 + ms;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Read and compare against the model; tag by register.
    task automatic rd_model(input logic [7:0] a);
        logic [31:0] d;
        rd(a, d);
        case (a)
            8'h10:   check("R5 ms read", d, m_rd);
            8'h0C:   check("R6 snapshot read", d, m_rd);
            default: check("R9 live/unmapped read", d, m_rd);
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, ms_v, sn_v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        rd(8'h08, d); check("R1 seconds after reset", d, 32'h0);
        rd(8'h0C, d); check("R1 snapshot after reset", d, 32'h0);
        rd(8'h10, d); check("R1 ms after reset", d, 32'h0);

        // R2/R7: tick spacing after a seconds write
        wr(8'h08, 32'd42);
        idle(P - 1);
        rd(8'h10, d); check("R2 ms before first tick", d, 32'd0);
        rd(8'h10, d); check("R2 ms after first tick", d, 32'd1);
        rd(8'h08, d); check("R7 seconds loaded", d, 32'd42);

        // R10: write lands on a tick edge
        wr(8'h08, 32'd100);
        idle(P - 1);
        wr(8'h08, 32'd200);
        rd(8'h10, d); check("R10 ms after write on tick", d, 32'd0);
        rd(8'h08, d); check("R10 seconds after write on tick", d, 32'd200);

        // R3/R5/R6: snapshot read on the rollover edge
        wr(8'h08, 32'd7);
        idle(1000 * P - 1);
        rd(8'h10, ms_v); check("R5 ms at rollover edge", ms_v, 32'd999);
        rd(8'h0C, sn_v); check("R5 snapshot pre-rollover", sn_v, 32'd7);
        check("R6 combined pair", combined(sn_v, ms_v), 32'd7999);
        rd(8'h08, d); check("R3 seconds incremented", d, 32'd8);

        // R4: seconds wrap
        wr(8'h08, 32'hFFFF_FFFF);
        idle(1000 * P);
        rd(8'h08, d); check("R4 seconds wrapped", d, 32'h0);

        // R8: writes to read-only and unmapped offsets
        rd(8'h10, d);
        rd(8'h0C, sn_v);
        wr(8'h0C, 32'hDEAD_BEEF);
        wr(8'h10, 32'h0000_0123);
        wr(8'h14, 32'h1234_5678);
        rd(8'h0C, d); check("R8 snapshot unchanged", d, sn_v);
        rd(8'h08, d); check("R8 seconds unchanged", d, m_rd);
        rd(8'h14, d); check("R9 unmapped reads zero", d, 32'h0);

        // Random mix checked against the model
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r <= 4) begin
                int k;
                k = $urandom_range(0, 5);
                case (k)
                    0: rd_model(8'h08);
                    1: rd_model(8'h0C);
                    2: rd_model(8'h10);
                    3: rd_model(8'h00);
                    4: rd_model(8'h14);
                    default: rd_model(8'h04);
                endcase
            end else if (r <= 6) begin
                idle($urandom_range(1, 20));
            end else if (r == 7) begin
                wr(($urandom_range(0, 1) != 0) ? 8'h0C : 8'h10, $urandom());
                rd_model(8'h0C);
            end else if (r == 8) begin
                wr(8'h08, ($urandom_range(0, 1) != 0) ? $urandom()
                          : 32'hFFFF_FFFF - 32'($urandom_range(0, 3)));
                rd_model(8'h08);
            end else begin
                rd(8'h10, ms_v); check("R5 pair ms", ms_v, m_rd);
                idle($urandom_range(0, 5));
                rd(8'h0C, sn_v); check("R6 pair snapshot", sn_v, m_rd);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule